// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small single-issue CPU core and decides when the core must divert into an interrupt handler and to which vector. Each of its sources is one of two kinds, fixed per source by a parameter. A flagged source has a sticky flag that any cycle with its input high will set. A level source has no flag and asks for service only while its input is high. Every source has its own enable, and a global enable gates all of them. When at least one enabled request is present, the global enable is on and the sequencer allows it, the block raises a one-cycle take strobe together with the vector of the most urgent request.

The core reports two events to the block: each retired instruction and each return-from-interrupt. Taking an interrupt drops the global enable and clears the flag of the chosen source. A return sets the global enable again, and the block then waits for one retired instruction before it may take again, so the interrupted program always makes progress. Software may also set or clear the global enable directly, and may clear flags by writing ones. Setting the enable inside a handler permits nesting.

The sequencer has two states. ST_RUN allows interrupts to be taken; a return moves it to ST_HOLD (transition "return"). ST_HOLD blocks every take and goes back to ST_RUN on the first retired-instruction strobe that does not coincide with another return (transition "retire").

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the global enable reads 0, no take is raised, the vector reads 0 and every flag is clear.
- R2: When several enabled requests are present, the lowest-numbered source wins; the vector equals the source number plus one (vector 0 is reserved for reset and appears whenever no take is raised).
- R3: A take is raised only while the global enable is on and the chosen source is enabled; the cycle after a take the global enable reads 0.
- R4: A flagged source (its bit in LEVEL_MASK is 0) latches a request on any cycle its input is high; taking its vector clears the flag, so it is not taken again without a new event.
- R5: Writing 1 to a bit of the flag-clear input clears that flag; when the input of the same source is also high in that cycle, the flag stays set.
- R6: A flag set while its source enable or the global enable is off stays pending and is taken, in priority order, once both are on.
- R7: A level source (its bit in LEVEL_MASK is 1; sources 12 to 15 by default) requests service only in cycles where its input is high and it is enabled; a level pulse that ends before it is enabled leaves no request.
- R8: A return strobe sets the global enable for the next cycle; no take is raised in the return cycle or afterwards until one retired-instruction strobe has been seen in a later cycle.
- R9: A global-disable command blocks a take in the same cycle and leaves the global enable at 0 in the next cycle, even when a set command or a return arrives together with it.
- R10: A set command issued while a handler runs (global enable 0 after a take) lets another pending request be taken, which nests it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_SRC | Event strobes (flagged sources) or request levels (level sources) |
| src_en | input | NUM_SRC | Per-source enables |
| flag_clr | input | NUM_SRC | Write-one-to-clear strobes for the flags |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable, effective at once |
| insn_done | input | 1 | One instruction retired in this cycle |
| reti | input | 1 | Return-from-interrupt executed in this cycle |
| irq_take | output | 1 | Divert the core to the vector this cycle |
| irq_vec | output | VEC_W | Vector index of the taken source, 0 when idle |
| gie | output | 1 | Present global-enable state |

## Verification
The checker watches on every cycle that a take requires the global enable and drops it one cycle later, that a disable command never coincides with a take, that no take follows directly after a return, that the vector stays in range and reads zero when idle, and that a return not paired with a disable turns the enable back on. Which source wins under contention, that flags survive disabled periods and vanish after service, the set-wins rule against a software clear, the loss of short level pulses and the single guaranteed instruction after a return depend on histories of several cycles, and only the bench's scenarios, checked against its own model, show them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } irqc_state_e;

endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int                  NUM_SRC    = 16,
    parameter logic [NUM_SRC-1:0]  LEVEL_MASK = 16'hF000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] flag_clr,
    input  logic [NUM_SRC-1:0] svc_clr,
    output logic [NUM_SRC-1:0] req
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (LEVEL_MASK[i]) begin : g_level
            // no storage: the request lives only as long as the input
            assign req[i] = src_en[i] & src_in[i];
        end else begin : g_flag
            logic flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (src_in[i]) begin
                    flag_q <= 1'b1;          // a new event beats any clear
                end else if (flag_clr[i] || svc_clr[i]) begin
                    flag_q <= 1'b0;
                end
            end
            assign req[i] = src_en[i] & flag_q;
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any_req,
    output logic [VEC_W-1:0]   win_vec
);

    always_comb begin
        win_vec = '0;
        // scan downwards so the lowest index is written last and wins
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_vec = VEC_W'(i + 1);
            end
        end
        any_req = |req;
    end

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gie_set,
    input  logic gie_clr,
    input  logic insn_done,
    input  logic reti,
    input  logic any_req,
    output logic take,
    output logic gie
);

    irqc_state_e state_q, state_d;
    logic        gie_q, gie_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            gie_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            gie_q   <= gie_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                take = gie_q && any_req && !gie_clr && !reti;
                if (reti) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (insn_done && !reti) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase

        if (gie_clr || take) begin
            gie_d = 1'b0;
        end else if (gie_set || reti) begin
            gie_d = 1'b1;
        end else begin
            gie_d = gie_q;
        end
    end

    assign gie = gie_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int                  NUM_SRC    = 16,
    parameter logic [NUM_SRC-1:0]  LEVEL_MASK = 16'hF000,
    localparam int                 VEC_W      = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] flag_clr,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               insn_done,
    input  logic               reti,
    output logic               irq_take,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               gie
);

    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] svc_clr;
    logic               any_req;
    logic [VEC_W-1:0]   win_vec;
    logic               take;

    irqc_flags #(
        .NUM_SRC   (NUM_SRC),
        .LEVEL_MASK(LEVEL_MASK)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .src_en  (src_en),
        .flag_clr(flag_clr),
        .svc_clr (svc_clr),
        .req     (req)
    );

    irqc_prio #(
        .NUM_SRC(NUM_SRC),
        .VEC_W  (VEC_W)
    ) u_prio (
        .req    (req),
        .any_req(any_req),
        .win_vec(win_vec)
    );

    irqc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie_set  (gie_set),
        .gie_clr  (gie_clr),
        .insn_done(insn_done),
        .reti     (reti),
        .any_req  (any_req),
        .take     (take),
        .gie      (gie)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_svc
        assign svc_clr[i] = take && (win_vec == VEC_W'(i + 1));
    end

    assign irq_take = take;
    assign irq_vec  = take ? win_vec : '0;

endmodule

// File: rtl/irqc_check.sv
module irqc_check #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gie_set,
    input logic             gie_clr,
    input logic             reti,
    input logic             irq_take,
    input logic [VEC_W-1:0] irq_vec,
    input logic             gie
);

    AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> gie);  // R3

    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !gie);  // R3

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vec != '0 && irq_vec <= VEC_W'(NUM_SRC)));  // R2

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |-> (irq_vec == '0));  // R2

    AST_RETURN_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !gie_clr) |=> gie);  // R8

    AST_NO_TAKE_AFTER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq_take);  // R8

    AST_DISABLE_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |-> !irq_take);  // R9

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !gie);  // R9

    AST_SET_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_set && !gie_clr && !irq_take) |=> gie);  // R10

endmodule

bind irq_prio_ctrl irqc_check #(
    .NUM_SRC(NUM_SRC),
    .VEC_W  (VEC_W)
) u_irqc_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .gie_set (gie_set),
    .gie_clr (gie_clr),
    .reti    (reti),
    .irq_take(irq_take),
    .irq_vec (irq_vec),
    .gie     (gie)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

    localparam int              N     = 16;
    localparam int              VW    = $clog2(N + 1);
    localparam logic [N-1:0]    LVL   = 16'hF000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_in = '0, src_en = '0, flag_clr = '0;
    logic          gie_set = 1'b0, gie_clr = 1'b0, insn_done = 1'b0, reti = 1'b0;
    logic          irq_take;
    logic [VW-1:0] irq_vec;
    logic          gie;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // bench model state
    logic [N-1:0]  m_flag = '0;
    logic          m_gie  = 1'b0;
    logic          m_hold = 1'b0;
    logic          s_take;
    logic [VW-1:0] s_vec;
    logic          s_gie;

    always #5 clk = ~clk;

    irq_prio_ctrl #(.NUM_SRC(N), .LEVEL_MASK(LVL)) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
        .flag_clr(flag_clr), .gie_set(gie_set), .gie_clr(gie_clr),
        .insn_done(insn_done), .reti(reti), .irq_take(irq_take),
        .irq_vec(irq_vec), .gie(gie)
    );

    function automatic logic [VW-1:0] exp_winner(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return VW'(i + 1);
        return '0;
    endfunction

    function automatic logic [N-1:0] exp_req();
        return src_en & ((LVL & src_in) | (~LVL & m_flag));
    endfunction

    function automatic logic exp_take();
        return m_gie && !m_hold && !gie_clr && !reti && (exp_req() != '0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: sample outputs mid-cycle, compare to model, then advance the model
    task automatic cyc();
        logic          t;
        logic [VW-1:0] v;
        #2;
        t = exp_take();
        v = t ? exp_winner(exp_req()) : '0;
        s_take = irq_take; s_vec = irq_vec; s_gie = gie;
        chk("R3 take", 32'(irq_take), 32'(t));
        chk("R2 vector", 32'(irq_vec), 32'(v));
        chk("R8 gie", 32'(gie), 32'(m_gie));
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (!LVL[i]) begin
                if (src_in[i]) m_flag[i] = 1'b1;
                else if (flag_clr[i] || (t && v == VW'(i + 1))) m_flag[i] = 1'b0;
            end
        end
        if (gie_clr || t) m_gie = 1'b0;
        else if (gie_set || reti) m_gie = 1'b1;
        if (reti) m_hold = 1'b1;
        else if (insn_done) m_hold = 1'b0;
        @(negedge clk);
        src_in = src_in & LVL;   // event strobes last one cycle
        flag_clr = '0; gie_set = 0; gie_clr = 0; insn_done = 0; reti = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 gie", 32'(gie), 0);
        chk("R1 take", 32'(irq_take), 0);
        chk("R1 vec", 32'(irq_vec), 0);
        rst_n = 1'b1;
        @(negedge clk);
        src_en = '1;
        cyc();
        chk("R1 no pending", 32'(s_take), 0);

        // R6: events while global enable is off stay latched
        src_in[5] = 1; src_in[2] = 1; cyc();
        cyc(); cyc();
        chk("R6 held while disabled", 32'(s_take), 0);
        gie_set = 1; cyc();
        // R2: lowest source wins, vector = source + 1
        cyc();
        chk("R2 winner", 32'(s_vec), 3);
        // R3: global enable off after take
        cyc();
        chk("R3 gie dropped", 32'(s_gie), 0);
        // R10: nested take by setting enable inside the handler
        gie_set = 1; cyc();
        cyc();
        chk("R10 nested take", 32'(s_vec), 6);
        // R8: return, then exactly one instruction before the next take
        src_in[7] = 1; cyc();
        reti = 1; cyc();
        chk("R8 no take on return", 32'(s_take), 0);
        cyc();
        chk("R8 gie set", 32'(s_gie), 1);
        chk("R8 hold", 32'(s_take), 0);
        insn_done = 1; cyc();
        chk("R8 still held", 32'(s_take), 0);
        cyc();
        chk("R8 take after one insn", 32'(s_vec), 8);
        // R4: serviced flags do not come back
        reti = 1; cyc(); insn_done = 1; cyc(); cyc();
        chk("R4 flags cleared", 32'(s_take), 0);

        // R5: clear alone removes the flag; set beats clear in the same cycle
        gie_clr = 1; cyc();
        src_in[3] = 1; cyc();
        flag_clr[3] = 1; cyc();
        src_in[1] = 1; flag_clr[1] = 1; cyc();
        gie_set = 1; cyc();
        cyc();
        chk("R5 set wins over clear", 32'(s_vec), 2);
        gie_set = 1; cyc();
        cyc();
        chk("R5 cleared flag gone", 32'(s_take), 0);

        // R6: flag with its own enable off waits for the enable
        src_en[9] = 0; src_in[9] = 1; cyc();
        cyc();
        chk("R6 source disabled", 32'(s_take), 0);
        src_en[9] = 1; cyc();
        chk("R6 taken once enabled", 32'(s_vec), 10);

        // R7: a level pulse that ends before enabling is lost
        src_en[12] = 0; src_in[12] = 1; cyc();
        src_in[12] = 0; cyc();
        src_en[12] = 1; gie_set = 1; cyc();
        cyc();
        chk("R7 pulse lost", 32'(s_take), 0);
        src_in[12] = 1; cyc();
        chk("R7 level taken", 32'(s_vec), 13);

        // R9: disable wins in the same cycle, also against a set
        gie_set = 1; cyc();
        gie_clr = 1; gie_set = 1; cyc();
        chk("R9 blocked same cycle", 32'(s_take), 0);
        cyc();
        chk("R9 gie off", 32'(s_gie), 0);
        src_in[12] = 0;
        cyc();

        // random phase against the model
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < 3000; k++) begin
            src_in   = (($urandom() & $urandom() & $urandom()) & ~LVL)
                     | (($urandom() % 4 == 0) ? ($urandom() & LVL) : (src_in & LVL));
            src_en   = ($urandom() % 8 == 0) ? N'($urandom()) : src_en;
            flag_clr = ($urandom() % 6 == 0) ? N'($urandom()) : '0;
            gie_set  = ($urandom() % 5 == 0);
            gie_clr  = ($urandom() % 12 == 0);
            reti     = ($urandom() % 7 == 0);
            insn_done = ($urandom() % 2 == 0);
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule